// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, cycle by cycle, when a decoded floating-point instruction may start in a pipelined FP unit that works on a register stack. One instruction is offered at a time on the input side. The block either raises `issue` in that cycle or raises `stall`. The offering side holds the same instruction until it sees `issue`. Only the timing of issue is modelled; no data moves through the block.

Three pieces of state set the timing. The first is a down-counter per physical register that holds how long that register's result is still pending. The second is a rename table that maps stack positions to physical registers; an exchange swaps two entries of this table. The third is a small control state machine. Its states are `S_OPEN`, where issue is allowed when the per-class rules pass; `S_DIVIDE`, where the non-pipelined divider holds the whole unit; and `S_GAP`, the single dead cycle after a store.

The transitions are:
- `S_OPEN` goes to `S_DIVIDE` when a divide issues.
- `S_OPEN` goes to `S_GAP` when a store issues.
- `S_OPEN` stays in `S_OPEN` for every other case.
- `S_GAP` goes to `S_OPEN` after one cycle.
- `S_DIVIDE` goes to `S_OPEN` when its occupancy counter reaches its last cycle.

A separate flag records that a multiply issued in the previous cycle.

Top module: `fpsb_issue`

## Requirements
- R1: During reset and just after it, `issue` and `stall` are both low while `in_valid` is low. After reset all registers are free, stack position i maps to physical register i, and an instruction with no hazard issues in the first cycle it is offered.
- R2: Operation codes on `in_op` are 0 add, 1 subtract, 2 multiply, 3 divide, 4 load, 5 store, 6 exchange and 7 no-op. `stall` is high exactly when `in_valid` is high and `issue` is low.
- R3: Independent add and subtract instructions issue in consecutive cycles with no stall.
- R4: An add, subtract, multiply or divide reads the stack positions `in_src_a` and `in_src_b`. If either source was written by an add, subtract or multiply issued in cycle N, the reading instruction issues no earlier than cycle N+3. A dependent instruction offered directly after its producer therefore stalls 2 cycles.
- R5: A multiply cannot issue in the cycle right after another multiply issued, even when the two are independent; it stalls 1 cycle. A multiply two cycles after another multiply issues without stalling.
- R6: A store reads `in_src_a`. If that register was written by an add, subtract or multiply issued in cycle N, the store issues no earlier than cycle N+4.
- R7: No instruction of any class issues in the cycle right after a store issued.
- R8: A divide samples `prec_ext` in its issue cycle. Its occupancy is 33 cycles when `prec_ext` is 0 and 39 cycles when it is 1. No instruction issues until that many cycles after the divide issued.
- R9: A load writes `in_dst` with no latency. An instruction that reads the loaded register may issue in the next cycle, even if an earlier arithmetic result to that register was still pending.
- R10: An exchange issues without adding a cycle. It swaps the physical registers behind stack position 0 and stack position `in_src_a`, and a pending result stays with its physical register.
- R11: A no-op issues under the same state rules as other instructions and changes no register state. In particular, it does not count as a multiply for R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 3 | Operation code (see R2) |
| in_src_a | input | IW | First source stack position (also the exchange partner) |
| in_src_b | input | IW | Second source stack position |
| in_dst | input | IW | Destination stack position |
| prec_ext | input | 1 | Selects the longer divide occupancy |
| issue | output | 1 | The offered instruction starts this cycle |
| stall | output | 1 | The offered instruction must be held |

## Verification
The bench builds the block with its default parameters: eight stack registers, an arithmetic latency of 3, and divide occupancies of 33 and 39. These values put both divide lengths and their full occupancy windows within a short run. They also leave enough registers to set up independent streams alongside dependent chains. An exchange can move a pending result away from stack position 0 and then be followed by reads through both of the swapped positions.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_DIV   = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5,
        OP_XCHG  = 3'd6,
        OP_NOP   = 3'd7
    } fp_op_e;

    typedef enum logic [1:0] {
        S_OPEN   = 2'd0,
        S_DIVIDE = 2'd1,
        S_GAP    = 2'd2
    } issue_state_e;
endpackage

// File: rtl/fpsb_rename.sv
module fpsb_rename #(
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap_en,
    input  logic [IW-1:0] swap_idx,
    input  logic [IW-1:0] lidx_a,
    input  logic [IW-1:0] lidx_b,
    input  logic [IW-1:0] lidx_d,
    output logic [IW-1:0] pidx_a,
    output logic [IW-1:0] pidx_b,
    output logic [IW-1:0] pidx_d
);
    logic [IW-1:0] map_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) map_q[i] <= IW'(i);
        end else if (swap_en) begin
            map_q[0]        <= map_q[swap_idx];
            map_q[swap_idx] <= map_q[0];
        end
    end

    assign pidx_a = map_q[lidx_a];
    assign pidx_b = map_q[lidx_b];
    assign pidx_d = map_q[lidx_d];

    // R10: the register behind the exchange partner moves to stack top
    p_swap_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> map_q[0] == $past(map_q[swap_idx]));
endmodule

// File: rtl/fpsb_busy.sv
module fpsb_busy #(
    parameter int NREG      = 8,
    parameter int IW        = $clog2(NREG),
    parameter int ARITH_LAT = 3,
    parameter int CW        = $clog2(ARITH_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [IW-1:0] rd_a,
    input  logic [IW-1:0] rd_b,
    output logic [CW-1:0] cnt_a,
    output logic [CW-1:0] cnt_b
);
    logic [CW-1:0] cnt_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                            cnt_q[g] <= '0;
            else if (set_en && wr_idx == IW'(g))   cnt_q[g] <= CW'(ARITH_LAT);
            else if (clr_en && wr_idx == IW'(g))   cnt_q[g] <= '0;
            else if (cnt_q[g] != '0)               cnt_q[g] <= cnt_q[g] - 1'b1;
        end

        // R4: a pending count only falls by one per cycle unless rewritten
        p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] > CW'(1) && !(wr_idx == IW'(g) && (set_en || clr_en)))
            |=> cnt_q[g] == $past(cnt_q[g]) - 1'b1);
    end

    assign cnt_a = cnt_q[rd_a];
    assign cnt_b = cnt_q[rd_b];
endmodule

// File: rtl/fpsb_ctrl.sv
module fpsb_ctrl
    import fpsb_pkg::*;
#(
    parameter int DIV_DBL = 33,
    parameter int DIV_EXT = 39,
    parameter int DW      = $clog2(DIV_EXT)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  fp_op_e op,
    input  logic   prec_ext,
    input  logic   deps_ok,
    output logic   issue
);
    issue_state_e  state_q, state_d;
    logic [DW-1:0] div_q;
    logic          mul_last_q;
    logic          can_go;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN: begin
                if (issue && op == OP_DIV)        state_d = S_DIVIDE;
                else if (issue && op == OP_STORE) state_d = S_GAP;
            end
            S_DIVIDE: if (div_q == DW'(1))        state_d = S_OPEN;
            S_GAP:                                state_d = S_OPEN;
            default:                              state_d = S_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_OPEN;
            div_q      <= '0;
            mul_last_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            mul_last_q <= issue && op == OP_MUL;
            if (issue && op == OP_DIV)
                div_q <= prec_ext ? DW'(DIV_EXT - 1) : DW'(DIV_DBL - 1);
            else if (div_q != '0)
                div_q <= div_q - 1'b1;
        end
    end

    always_comb begin
        can_go = 1'b0;
        unique case (state_q)
            S_OPEN:   can_go = deps_ok && !(op == OP_MUL && mul_last_q);
            S_DIVIDE: can_go = 1'b0;
            S_GAP:    can_go = 1'b0;
            default:  can_go = 1'b0;
        endcase
        issue = in_valid && can_go;
    end

    // R5: two multiplies never start in adjacent cycles
    p_mul_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_MUL) |=> !(issue && op == OP_MUL));
    // R7: the cycle after a store is dead
    p_store_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_STORE) |=> !issue);
    // R8: nothing starts right after a divide
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_DIV) |=> !issue);
    // R8: occupancy ends by returning to the open state
    p_div_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DIVIDE && div_q == DW'(1)) |=> state_q == S_OPEN);
endmodule

// File: rtl/fpsb_issue.sv
module fpsb_issue
    import fpsb_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int IW        = $clog2(NREG),
    parameter int ARITH_LAT = 3,
    parameter int DIV_DBL   = 33,
    parameter int DIV_EXT   = 39
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [IW-1:0] in_src_a,
    input  logic [IW-1:0] in_src_b,
    input  logic [IW-1:0] in_dst,
    input  logic          prec_ext,
    output logic          issue,
    output logic          stall
);
    localparam int CW = $clog2(ARITH_LAT + 1);

    fp_op_e        op;
    logic [IW-1:0] pa, pb, pd;
    logic [CW-1:0] cnt_a, cnt_b;
    logic          reads_two, reads_store, deps_ok, is_arith;

    assign op          = fp_op_e'(in_op);
    assign reads_two   = op inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV};
    assign reads_store = op == OP_STORE;
    assign is_arith    = op inside {OP_ADD, OP_SUB, OP_MUL};

    always_comb begin
        if (reads_two)        deps_ok = cnt_a <= CW'(1) && cnt_b <= CW'(1);
        else if (reads_store) deps_ok = cnt_a == '0;
        else                  deps_ok = 1'b1;
    end

    fpsb_rename #(.NREG(NREG), .IW(IW)) u_rename (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_en  (issue && op == OP_XCHG),
        .swap_idx (in_src_a),
        .lidx_a   (in_src_a),
        .lidx_b   (in_src_b),
        .lidx_d   (in_dst),
        .pidx_a   (pa),
        .pidx_b   (pb),
        .pidx_d   (pd)
    );

    fpsb_busy #(.NREG(NREG), .IW(IW), .ARITH_LAT(ARITH_LAT), .CW(CW)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (issue && is_arith),
        .clr_en (issue && op == OP_LOAD),
        .wr_idx (pd),
        .rd_a   (pa),
        .rd_b   (pb),
        .cnt_a  (cnt_a),
        .cnt_b  (cnt_b)
    );

    fpsb_ctrl #(.DIV_DBL(DIV_DBL), .DIV_EXT(DIV_EXT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (op),
        .prec_ext (prec_ext),
        .deps_ok  (deps_ok),
        .issue    (issue)
    );

    assign stall = in_valid && !issue;

    // R4: a two-source instruction never starts on a result still in flight
    p_src_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && reads_two) |-> (cnt_a <= CW'(1) && cnt_b <= CW'(1)));
    // R6: a store starts only once its source is fully settled
    p_store_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && reads_store) |-> cnt_a == '0);
endmodule

// File: tb/sim_fpsb_issue.sv
module sim_fpsb_issue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = 3'd7;
    logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       prec_ext = 1'b0;
    logic       issue, stall;

    int total = 0, bad = 0;
    int busy_m [8];
    int map_m  [8];
    int div_left = 0;
    bit gap_m = 0, lastmul_m = 0;

    always #4 clk = ~clk;

    fpsb_issue u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .prec_ext(prec_ext), .issue(issue), .stall(stall)
    );

    function automatic bit model_can();
        int op = int'(in_op);
        int ca = busy_m[map_m[in_src_a]];
        int cb = busy_m[map_m[in_src_b]];
        bit dep = 1;
        if (op <= 3) dep = (ca <= 1) && (cb <= 1);
        else if (op == 5) dep = (ca == 0);
        return in_valid && div_left == 0 && !gap_m && !(op == 2 && lastmul_m) && dep;
    endfunction

    task automatic model_step(input bit went);
        int op = int'(in_op);
        int t;
        for (int i = 0; i < 8; i++) if (busy_m[i] > 0) busy_m[i]--;
        if (div_left > 0) div_left--;
        gap_m = 0;
        lastmul_m = 0;
        if (went) begin
            if (op <= 2) busy_m[map_m[in_dst]] = 3;
            if (op == 4) busy_m[map_m[in_dst]] = 0;
            if (op == 3) div_left = prec_ext ? 38 : 32;
            if (op == 5) gap_m = 1;
            if (op == 2) lastmul_m = 1;
            if (op == 6) begin
                t = map_m[0];
                map_m[0] = map_m[in_src_a];
                map_m[in_src_a] = t;
            end
        end
    endtask

    task automatic check_cycle(input string req, input bit exp);
        total++;
        if (issue !== exp || stall !== (in_valid && !exp)) begin
            bad++;
            $display("FAIL %s issue/stall=%b%b expected=%b%b", req, issue, stall,
                     exp, in_valid && !exp);
        end
    endtask

    task automatic idle(input string req, input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            #1 check_cycle(req, 1'b0);
            @(posedge clk); model_step(1'b0);
            @(negedge clk);
        end
    endtask

    task automatic run(input string req, input int op, input int a, input int b,
                       input int d, input bit prec, input int exp_stalls);
        int n = 0;
        bit e;
        in_valid = 1'b1; in_op = 3'(op); in_src_a = 3'(a); in_src_b = 3'(b);
        in_dst = 3'(d); prec_ext = prec;
        forever begin
            #1 e = model_can();
            check_cycle(req, e);
            @(posedge clk); model_step(e);
            @(negedge clk);
            if (e) break;
            n++;
            if (n > 100) break;
        end
        in_valid = 1'b0;
        total++;
        if (n != exp_stalls) begin
            bad++;
            $display("FAIL %s stall cycles=%0d expected=%0d", req, n, exp_stalls);
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin busy_m[i] = 0; map_m[i] = i; end
        repeat (3) @(negedge clk);
        total++;
        if (issue !== 1'b0 || stall !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset issue/stall=%b%b expected=00", issue, stall);
        end
        @(negedge clk); rst_n = 1'b1;
        idle("R1", 2);
        run("R1", 0, 1, 2, 3, 0, 0);
        // R3: independent add/sub stream
        run("R3", 1, 4, 5, 6, 0, 0);
        run("R3", 0, 1, 2, 7, 0, 0);
        idle("R3", 4);
        // R4: dependent chains
        run("R4", 0, 1, 2, 3, 0, 0);
        run("R4", 1, 3, 4, 5, 0, 2);
        run("R4", 2, 1, 2, 4, 0, 0);
        run("R4", 0, 1, 4, 5, 0, 2);
        idle("R4", 4);
        // R5: multiply spacing
        run("R5", 2, 1, 2, 3, 0, 0);
        run("R5", 2, 4, 5, 6, 0, 1);
        idle("R5", 4);
        run("R5", 2, 1, 2, 3, 0, 0);
        run("R5", 4, 0, 0, 7, 0, 0);
        run("R5", 2, 4, 5, 6, 0, 0);
        idle("R6", 4);
        // R6 / R7: store latency and dead cycle
        run("R6", 0, 1, 2, 3, 0, 0);
        run("R6", 5, 3, 0, 0, 0, 3);
        run("R7", 0, 1, 2, 4, 0, 1);
        idle("R6", 4);
        run("R6", 2, 1, 2, 5, 0, 0);
        run("R6", 5, 5, 0, 0, 0, 3);
        idle("R9", 4);
        run("R9", 4, 0, 0, 6, 0, 0);
        run("R9", 5, 6, 0, 0, 0, 0);
        idle("R8", 4);
        // R8: divide occupancy by precision
        run("R8", 3, 1, 2, 3, 0, 0);
        run("R8", 0, 4, 5, 6, 0, 32);
        idle("R8", 4);
        run("R8", 3, 1, 2, 3, 1, 0);
        run("R8", 0, 4, 5, 6, 0, 38);
        idle("R9", 4);
        // R9: load overrides a pending result
        run("R9", 0, 1, 2, 4, 0, 0);
        run("R9", 4, 0, 0, 4, 0, 0);
        run("R9", 0, 4, 1, 5, 0, 0);
        idle("R10", 4);
        // R10: exchange is free and pending state follows the register
        run("R10", 0, 1, 2, 0, 0, 0);
        run("R10", 6, 5, 0, 0, 0, 0);
        run("R10", 1, 5, 1, 3, 0, 1);
        run("R10", 0, 0, 1, 2, 0, 0);
        idle("R11", 4);
        // R11: no-op issues and is not a multiply
        run("R11", 2, 1, 2, 3, 0, 0);
        run("R11", 7, 0, 0, 0, 0, 0);
        run("R11", 2, 4, 5, 6, 0, 0);
        idle("R11", 4);
        run("R11", 5, 7, 0, 0, 0, 0);
        run("R11", 7, 0, 0, 0, 0, 1);
        idle("R2", 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule